// File: doc/BRIEF.md
# Cascadable serial configuration bitstream reader

This block is the read side of a bit-serial configuration memory. A loading device supplies the configuration clock. The block presents one stored bit at a time on a data output that is enabled only while the block is streaming, and it moves to the next bit on every rising edge. Bits leave the store least significant bit first within each byte. A single pin serves as both output enable and pointer reset. A stored polarity bit decides which level of that pin means "reset". This lets the same part sit behind either sense of the loader's reset line with no inverter.

Several copies can be daisy-chained. The chip-enable-out of one copy drives the chip enable of the next, so together they stream one continuous bitstream. After a global reset, a power-on interval of a set number of clocks holds the block quiet and keeps the ready flag low. While serial-enable is low the block is in programming mode. In that mode reading stops, and the byte store and the polarity bit can be written through a simple parallel port.

Top module: `cfg_bit_reader`

## Requirements
- R1: `data_en` is 1 only when all of these hold: `ready_o` is 1, `ser_en` is 1, `ce_n` is 0, the reset pin is at its non-reset level, and the store has not been fully read since the last reset. When `data_en` is 0, `data_o` is 0.
- R2: Output bit number k is bit (k mod 8) of byte k/8, so bytes go out least significant bit first. Each rising clock edge with `data_en` at 1 moves to bit k+1.
- R3: Holding the reset pin at its reset level for one clock edge, with `ser_en` high, clears the pointer and the exhausted state. The next bit presented is bit 0.
- R4: The reset level of `oe_rst` is 1 when the polarity bit is 1 and 0 when the polarity bit is 0. The polarity bit is written by `pol_we`/`pol_d` while `ser_en` is 0, and `rst_n` sets it to `POL_DEFAULT`.
- R5: While `ce_n` is 1, the pointer does not move and `data_en` is 0. When `ce_n` returns to 0, streaming resumes at the same bit.
- R6: On the clock edge that follows the last bit (`DEPTH_BITS`-1), `ceo_n` goes to 0 and `data_en` goes to 0 at the same time.
- R7: Once the store is exhausted, `ceo_n` equals `ce_n` while the reset pin is inactive and `ser_en` is 1. It goes to 1 when the reset pin reaches its reset level, and it stays 1 until the whole store has been read again.
- R8: After `rst_n` is released, `ready_o` stays 0 for exactly `POR_CYCLES` clock edges and then becomes 1. While `ready_o` is 0, `data_en` is 0 and the pointer is held at 0.
- R9: With `ser_en` at 0, `data_en` is 0, `ceo_n` is 1 and the pointer is frozen. Store writes (`cfg_we`) take effect only while `ser_en` is 0.
- R10: When two copies are chained through `ceo_n` → `ce_n`, the combined stream is the first image followed by the second image, bit for bit, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the loader |
| rst_n | input | 1 | Global asynchronous reset, active low; starts the power-on interval |
| ce_n | input | 1 | Chip enable, active low |
| oe_rst | input | 1 | Output enable / pointer reset pin; its reset level is set by the polarity bit |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| cfg_we | input | 1 | Byte store write strobe |
| cfg_addr | input | $clog2(DEPTH_BITS/8) | Byte address for writes |
| cfg_data | input | 8 | Byte to write |
| pol_we | input | 1 | Polarity bit write strobe |
| pol_d | input | 1 | New polarity value (1: high level resets) |
| data_o | output | 1 | Serial data bit |
| data_en | output | 1 | Output driver enable (0 models high impedance) |
| ceo_n | output | 1 | Chip enable out to the next device, active low |
| ready_o | output | 1 | Power-on interval done (released open-drain level) |

## Verification
The bench builds two chained copies with `DEPTH_BITS` = 64 and `POR_CYCLES` = 5. With only 64 bits per copy, a full pass through the last-bit handoff and through the whole chain takes a few hundred clocks. Each bit of both images is then compared to the byte layout. The short power-on interval lets the bench count, edge by edge, where `ready_o` is released. The small store also means that mid-stream resets, chip-enable pauses, serial-enable pauses and a polarity flip can each be placed at a chosen bit position.

// File: rtl/cfg_bit_reader.sv
module cfg_bit_reader #(
  parameter int DEPTH_BITS  = 2048,
  parameter int POR_CYCLES  = 32,
  parameter bit POL_DEFAULT = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ce_n,
  input  logic                            oe_rst,
  input  logic                            ser_en,
  input  logic                            cfg_we,
  input  logic [$clog2(DEPTH_BITS/8)-1:0] cfg_addr,
  input  logic [7:0]                      cfg_data,
  input  logic                            pol_we,
  input  logic                            pol_d,
  output logic                            data_o,
  output logic                            data_en,
  output logic                            ceo_n,
  output logic                            ready_o
);
  localparam int BYTES = DEPTH_BITS / 8;
  localparam int AW    = $clog2(DEPTH_BITS);
  localparam int PW    = $clog2(POR_CYCLES + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  logic [7:0]    mem [BYTES];
  logic          pol;
  logic [PW-1:0] por_cnt;
  logic [AW-1:0] ptr;
  logic          done;
  logic          rst_lvl;
  logic          run;
  logic          cur_bit;

  always_ff @(posedge clk)
    if (cfg_we && !ser_en) mem[cfg_addr] <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pol <= POL_DEFAULT;
    else if (pol_we && !ser_en) pol <= pol_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           por_cnt <= '0;
    else if (por_cnt != PW'(POR_CYCLES))  por_cnt <= por_cnt + 1'b1;

  assign ready_o = (por_cnt == PW'(POR_CYCLES));
  assign rst_lvl = pol ? oe_rst : !oe_rst;
  assign run     = ready_o && ser_en && !ce_n && !rst_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (!ready_o || (ser_en && rst_lvl)) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (run && !done) begin
      if (ptr == LAST) begin
        ptr  <= '0;
        done <= 1'b1;
      end else begin
        ptr  <= ptr + 1'b1;
      end
    end

  assign cur_bit = mem[ptr[AW-1:3]][ptr[2:0]];
  assign data_en = run && !done;
  assign data_o  = data_en & cur_bit;
  assign ceo_n   = !(done && run);
endmodule

// File: rtl/cfg_bit_reader_chk.sv
module cfg_bit_reader_chk #(
  parameter int DEPTH_BITS = 2048
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ce_n,
  input logic                          ser_en,
  input logic                          data_en,
  input logic                          ceo_n,
  input logic                          ready_o,
  input logic                          rst_lvl,
  input logic                          done,
  input logic [$clog2(DEPTH_BITS)-1:0] ptr
);
  localparam int AW = $clog2(DEPTH_BITS);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> (!ce_n && ser_en && ready_o && !rst_lvl && !done));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && ptr != LAST) |=> (ptr == AW'($past(ptr) + 1'b1)));

  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && rst_lvl) |=> (ptr == '0 && !done));

  assert_ce_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && ce_n && !(ser_en && rst_lvl)) |=> $stable(ptr));

  assert_last_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && ptr == LAST) |=> (done && ptr == '0));

  assert_exhausted_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !data_en);

  assert_por_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (!data_en && ptr == '0 && ceo_n));

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  assert_prog_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> (!data_en && ceo_n));

  assert_prog_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && ready_o) |=> $stable(ptr));
endmodule

bind cfg_bit_reader cfg_bit_reader_chk #(.DEPTH_BITS(DEPTH_BITS)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .ser_en  (ser_en),
  .data_en (data_en),
  .ceo_n   (ceo_n),
  .ready_o (ready_o),
  .rst_lvl (rst_lvl),
  .done    (done),
  .ptr     (ptr)
);

// File: tb/cfg_bit_reader_tb_top.sv
`timescale 1ns/1ps
module cfg_bit_reader_tb_top;
  localparam int DB  = 64;
  localparam int POR = 5;
  localparam int NB  = DB / 8;
  localparam int BAW = $clog2(NB);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ce0_n = 1'b0, oe_pin = 1'b0, ser_en = 1'b1;
  logic we0 = 1'b0, we1 = 1'b0, pol_we = 1'b0, pol_d = 1'b1;
  logic [BAW-1:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic d0, en0, ceo0, rdy0, d1, en1, ceo1, rdy1;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] img0 [NB];
  logic [7:0] img1 [NB];

  cfg_bit_reader #(.DEPTH_BITS(DB), .POR_CYCLES(POR), .POL_DEFAULT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce0_n), .oe_rst(oe_pin), .ser_en(ser_en),
    .cfg_we(we0), .cfg_addr(waddr), .cfg_data(wdata), .pol_we(pol_we), .pol_d(pol_d),
    .data_o(d0), .data_en(en0), .ceo_n(ceo0), .ready_o(rdy0));

  cfg_bit_reader #(.DEPTH_BITS(DB), .POR_CYCLES(POR), .POL_DEFAULT(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .ce_n(ceo0), .oe_rst(oe_pin), .ser_en(ser_en),
    .cfg_we(we1), .cfg_addr(waddr), .cfg_data(wdata), .pol_we(pol_we), .pol_d(pol_d),
    .data_o(d1), .data_en(en1), .ceo_n(ceo1), .ready_o(rdy1));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(int k);
    if (k < DB) return img0[k/8][k%8];
    return img1[(k-DB)/8][(k-DB)%8];
  endfunction

  task automatic chk_bit(int k, string req);
    chk(req, $sformatf("one driver at bit %0d", k), 32'(en0 ^ en1), 1);
    chk(req, $sformatf("stream bit %0d", k), 32'(en0 ? d0 : d1), 32'(exp_bit(k)));
  endtask

  task automatic read_bits(int from, int n, string req);
    for (int i = 0; i < n; i++) begin
      chk_bit(from + i, req);
      tick();
    end
  endtask

  task automatic restart();
    oe_pin = 1'b1;
    tick();
    oe_pin = 1'b0;
    #1;
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic t_por();
    tick();
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < POR; i++) begin
      chk("R8", "ready low in interval", 32'(rdy0), 0);
      chk("R8", "no drive in interval", 32'(en0), 0);
      tick();
    end
    chk("R8", "ready after interval", 32'(rdy0), 1);
    chk("R8", "drive after interval", 32'(en0), 1);
  endtask

  task automatic t_program();
    ser_en = 1'b0;
    #1;
    chk("R9", "no drive in programming", 32'(en0), 0);
    chk("R9", "ceo high in programming", 32'(ceo0), 1);
    for (int i = 0; i < NB; i++) begin
      waddr = BAW'(i);
      wdata = img0[i]; we0 = 1'b1; tick(); we0 = 1'b0;
      wdata = img1[i]; we1 = 1'b1; tick(); we1 = 1'b0;
    end
    ser_en = 1'b1;
    restart();
    chk_bit(0, "R3");
  endtask

  task automatic t_write_ignored();
    waddr = '0;
    wdata = ~img0[0];
    we0 = 1'b1;
    ser_en = 1'b1;
    tick();
    we0 = 1'b0;
    restart();
    read_bits(0, 8, "R9");
  endtask

  task automatic t_chain();
    restart();
    for (int k = 0; k < 2*DB; k++) begin
      chk_bit(k, "R10");
      tick();
      if (k == DB-1) begin
        chk("R6", "ceo0 low after last bit", 32'(ceo0), 0);
        chk("R6", "dev0 released", 32'(en0), 0);
      end
    end
    chk("R6", "dev1 released", 32'(en1), 0);
    chk("R6", "dev1 ceo low", 32'(ceo1), 0);
    chk("R2", "dev0 still released", 32'(en0), 0);
  endtask

  task automatic t_ceo_track();
    ce0_n = 1'b1;
    #1;
    chk("R7", "ceo follows ce high", 32'(ceo0), 1);
    tick();
    ce0_n = 1'b0;
    #1;
    chk("R7", "ceo follows ce low", 32'(ceo0), 0);
    tick(); tick();
    chk("R7", "ceo stays low", 32'(ceo0), 0);
    chk("R7", "no drive when exhausted", 32'(en0), 0);
    oe_pin = 1'b1;
    #1;
    chk("R7", "ceo high on reset level", 32'(ceo0), 1);
    tick();
    oe_pin = 1'b0;
    #1;
    chk("R7", "ceo high until reread", 32'(ceo0), 1);
    chk_bit(0, "R3");
    read_bits(0, 3, "R7");
    chk("R7", "ceo high mid reread", 32'(ceo0), 1);
  endtask

  task automatic t_midreset();
    restart();
    read_bits(0, 11, "R2");
    restart();
    read_bits(0, 4, "R3");
  endtask

  task automatic t_freeze();
    restart();
    read_bits(0, 5, "R5");
    ce0_n = 1'b1;
    #1;
    chk("R5", "no drive with ce high", 32'(en0), 0);
    tick(); tick(); tick();
    chk("R5", "still no drive", 32'(en0), 0);
    ce0_n = 1'b0;
    #1;
    read_bits(5, 3, "R5");
  endtask

  task automatic t_serdis();
    restart();
    read_bits(0, 3, "R9");
    ser_en = 1'b0;
    #1;
    chk("R9", "no drive when disabled", 32'(en0), 0);
    chk("R9", "ceo high when disabled", 32'(ceo0), 1);
    tick(); tick();
    ser_en = 1'b1;
    #1;
    read_bits(3, 3, "R9");
  endtask

  task automatic t_polarity();
    ser_en = 1'b0;
    pol_we = 1'b1; pol_d = 1'b0;
    tick();
    pol_we = 1'b0;
    ser_en = 1'b1;
    oe_pin = 1'b0;
    #1;
    chk("R4", "low level resets with pol 0", 32'(en0), 0);
    tick();
    oe_pin = 1'b1;
    #1;
    chk_bit(0, "R4");
    read_bits(0, 6, "R4");
    oe_pin = 1'b0;
    tick();
    oe_pin = 1'b1;
    #1;
    read_bits(0, 2, "R4");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      img0[i] = 8'hA5 ^ 8'(i * 37);
      img1[i] = 8'h3C + 8'(i * 29);
    end
    tick(); tick();
    t_por();
    t_program();
    t_write_ignored();
    t_chain();
    t_ceo_track();
    t_midreset();
    t_freeze();
    t_serdis();
    t_polarity();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule